// File: doc/BRIEF.md
# ECC Engine Control Register Block

This block is the software-facing control plane of an error-correction engine that has an encoder half and a decoder half. A 32-bit register bus (single-cycle write strobe, single-cycle read strobe, combinational read data) reaches a set of registers for each half: an enable register, a configuration word, an idle flag, an interrupt-enable bit and an interrupt-status bit. The encoder half adds a source-address register and a window of parity words. The parity words are captured from the encoder core when it finishes.

Each half drives a one-cycle start pulse to its core and waits for a done pulse back. Software can check progress through the idle flag or by enabling the interrupt. The configuration words go to the cores unchanged. The 5-bit strength code in bits [4:0] of each configuration word is also decoded into a correction capability in bits. A decoder run counts as complete only when the core's per-sector done mask has the bit of the last expected sector set. That sector index is programmed in the decoder enable register.

Top module: `ecc_regif`

## Requirements
- R1: After reset every idle register reads 1 in bit 0, every enable, interrupt-enable, interrupt-status and configuration register reads 0, both start outputs are 0 and `irq` is 0.
- R2: `enc_tcap`/`dec_tcap` give the capability for code c = cfg[4:0]: 4+2c for c in 0..10, 24+4(c-10) for c in 11..19, and 4 for any code above 19.
- R3: The configuration words (encoder 0x004, decoder 0x104) and the encoder source address (0x008) read back the last value written and appear unchanged on `enc_cfg`, `dec_cfg` and `enc_src_addr`.
- R4: A write with bit 0 = 1 to an enable register (encoder 0x000, decoder 0x100) while that half is idle raises its start output for exactly the one cycle after the write, and its idle register (0x00C / 0x10C) reads 0 from that cycle on.
- R5: An encoder done pulse while busy sets encoder idle bit 0 and interrupt status bit 0 (0x084) after the same edge, and latches the parity input words into 0x010 + 4*i.
- R6: The decoder enable register holds the last-sector index in bits [7:4]. A decoder done pulse ends the busy state in every case, but it sets decoder status (0x204) only when `dec_sector_mask` has that index's bit set.
- R7: Reading an interrupt-status register clears it after that read. A done event in the same cycle as the read wins, and the bit stays set.
- R8: `irq` is 1 exactly when some half has both interrupt status bit 0 and interrupt-enable bit 0 (0x080 / 0x200) set.
- R9: Reads from offsets not listed in R1 to R8 return 0. 0x124 returns the live `dec_sector_mask`.
- R10: A write of bit 0 = 1 to an enable register while that half is busy produces no start pulse. Writing bit 0 = 0 clears the enable bit but leaves the busy state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status registers on read) |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| enc_start | output | 1 | One-cycle encoder start pulse |
| enc_done | input | 1 | Encoder completion pulse |
| enc_parity | input | 32*PAR_WORDS | Encoder parity words, word i in bits [32i+31:32i] |
| enc_cfg | output | 32 | Encoder configuration word |
| enc_src_addr | output | 32 | Encoder source address |
| enc_tcap | output | 6 | Decoded encoder capability in bits |
| dec_start | output | 1 | One-cycle decoder start pulse |
| dec_done | input | 1 | Decoder completion pulse |
| dec_sector_mask | input | SECTORS | Per-sector done mask from the decoder core |
| dec_cfg | output | 32 | Decoder configuration word |
| dec_tcap | output | 6 | Decoded decoder capability in bits |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational, so the bench samples it one time unit after it drives the address. This happens before the edge that applies a read-clear. Start pulses and the idle flag are registered on the write edge. Status, idle and parity are registered on the done edge. Every check on these results is made one time unit after that edge. `irq` and the capability outputs are combinational from registers and are sampled in the same way. For pulse width, the start output is checked again one edge later to confirm that it has already dropped.

// File: rtl/ecc_regif_pkg.sv
package ecc_regif_pkg;
  localparam logic [11:0] OFS_ENC_CTL  = 12'h000;
  localparam logic [11:0] OFS_ENC_CFG  = 12'h004;
  localparam logic [11:0] OFS_ENC_SRC  = 12'h008;
  localparam logic [11:0] OFS_ENC_IDLE = 12'h00C;
  localparam logic [11:0] OFS_ENC_PAR  = 12'h010;
  localparam logic [11:0] OFS_ENC_IE   = 12'h080;
  localparam logic [11:0] OFS_ENC_IS   = 12'h084;
  localparam logic [11:0] OFS_DEC_CTL  = 12'h100;
  localparam logic [11:0] OFS_DEC_CFG  = 12'h104;
  localparam logic [11:0] OFS_DEC_IDLE = 12'h10C;
  localparam logic [11:0] OFS_DEC_MASK = 12'h124;
  localparam logic [11:0] OFS_DEC_IE   = 12'h200;
  localparam logic [11:0] OFS_DEC_IS   = 12'h204;

  // capability in bits for a 5-bit strength code
  function automatic logic [5:0] cap_bits(input logic [4:0] code);
    int c;
    c = int'(code);
    if (c <= 10)      return 6'(4 + 2 * c);
    else if (c <= 19) return 6'(24 + 4 * (c - 10));
    else              return 6'd4;
  endfunction
endpackage

// File: rtl/ecc_half_ctrl.sv
module ecc_half_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr,
  input  logic en_bit,
  input  logic ie_wr,
  input  logic ie_bit,
  input  logic sta_rd,
  input  logic done_i,
  input  logic done_ok_i,
  output logic en_o,
  output logic ie_o,
  output logic busy_o,
  output logic sta_o,
  output logic start_o
);
  logic start_ev, finish_ev, post_ev;

  assign start_ev  = en_wr && en_bit && !busy_o;
  assign finish_ev = done_i && busy_o;
  assign post_ev   = finish_ev && done_ok_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o    <= 1'b0;
      ie_o    <= 1'b0;
      busy_o  <= 1'b0;
      sta_o   <= 1'b0;
      start_o <= 1'b0;
    end else begin
      if (en_wr) en_o <= en_bit;
      if (ie_wr) ie_o <= ie_bit;
      start_o <= start_ev;
      if (start_ev)       busy_o <= 1'b1;
      else if (finish_ev) busy_o <= 1'b0;
      if (post_ev)        sta_o <= 1'b1;
      else if (sta_rd)    sta_o <= 1'b0;
    end
  end

  // R4: start pulse lasts one cycle and implies busy
  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_o);
  // R5: done while busy returns to idle
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && busy_o) |=> !busy_o);
  // R7: read without done clears status
  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_rd && !done_i) |=> !sta_o);
  // R10: no start while busy
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i) |=> !start_o);
endmodule

// File: rtl/ecc_parity_bank.sv
module ecc_parity_bank #(
  parameter int WORDS = 8,
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap,
  input  logic [WORDS*32-1:0] par_i,
  input  logic [IW-1:0]      sel,
  output logic [31:0]        word_o
);
  logic [31:0] store [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   store[g] <= '0;
      else if (cap) store[g] <= par_i[g*32 +: 32];
    end
  end

  assign word_o = (int'(sel) < WORDS) ? store[sel] : 32'd0;
endmodule

// File: rtl/ecc_regif.sv
module ecc_regif
  import ecc_regif_pkg::*;
#(
  parameter int PAR_WORDS = 8,
  parameter int SECTORS   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [11:0]            bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   enc_start,
  input  logic                   enc_done,
  input  logic [PAR_WORDS*32-1:0] enc_parity,
  output logic [31:0]            enc_cfg,
  output logic [31:0]            enc_src_addr,
  output logic [5:0]             enc_tcap,
  output logic                   dec_start,
  input  logic                   dec_done,
  input  logic [SECTORS-1:0]     dec_sector_mask,
  output logic [31:0]            dec_cfg,
  output logic [5:0]             dec_tcap,
  output logic                   irq
);
  localparam int IW = (PAR_WORDS > 1) ? $clog2(PAR_WORDS) : 1;
  localparam int SW = (SECTORS > 1) ? $clog2(SECTORS) : 1;

  logic enc_en, enc_ie, enc_busy, enc_sta;
  logic dec_en, dec_ie, dec_busy, dec_sta;
  logic [SW-1:0] dec_last;
  logic dec_ok;
  logic enc_cap;
  logic [11:0] par_off;
  logic par_hit;
  logic [31:0] par_word;

  function automatic logic wr_at(input logic [11:0] a);
    return bus_wr && (bus_addr == a);
  endfunction

  // encoder half
  ecc_half_ctrl u_enc (
    .clk(clk), .rst_n(rst_n),
    .en_wr(wr_at(OFS_ENC_CTL)), .en_bit(bus_wdata[0]),
    .ie_wr(wr_at(OFS_ENC_IE)),  .ie_bit(bus_wdata[0]),
    .sta_rd(bus_rd && bus_addr == OFS_ENC_IS),
    .done_i(enc_done), .done_ok_i(1'b1),
    .en_o(enc_en), .ie_o(enc_ie), .busy_o(enc_busy), .sta_o(enc_sta),
    .start_o(enc_start));

  // decoder half: completion qualified by last-sector bit
  assign dec_ok = dec_sector_mask[dec_last];

  ecc_half_ctrl u_dec (
    .clk(clk), .rst_n(rst_n),
    .en_wr(wr_at(OFS_DEC_CTL)), .en_bit(bus_wdata[0]),
    .ie_wr(wr_at(OFS_DEC_IE)),  .ie_bit(bus_wdata[0]),
    .sta_rd(bus_rd && bus_addr == OFS_DEC_IS),
    .done_i(dec_done), .done_ok_i(dec_ok),
    .en_o(dec_en), .ie_o(dec_ie), .busy_o(dec_busy), .sta_o(dec_sta),
    .start_o(dec_start));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_cfg      <= '0;
      enc_src_addr <= '0;
      dec_cfg      <= '0;
      dec_last     <= '0;
    end else begin
      if (wr_at(OFS_ENC_CFG)) enc_cfg      <= bus_wdata;
      if (wr_at(OFS_ENC_SRC)) enc_src_addr <= bus_wdata;
      if (wr_at(OFS_DEC_CFG)) dec_cfg      <= bus_wdata;
      if (wr_at(OFS_DEC_CTL)) dec_last     <= bus_wdata[4 +: SW];
    end
  end

  assign enc_tcap = cap_bits(enc_cfg[4:0]);
  assign dec_tcap = cap_bits(dec_cfg[4:0]);

  // parity window
  assign enc_cap = enc_done && enc_busy;
  assign par_off = bus_addr - OFS_ENC_PAR;
  assign par_hit = (bus_addr >= OFS_ENC_PAR) && (par_off[1:0] == 2'b00) &&
                   (int'(par_off[11:2]) < PAR_WORDS);

  ecc_parity_bank #(.WORDS(PAR_WORDS)) u_par (
    .clk(clk), .rst_n(rst_n), .cap(enc_cap), .par_i(enc_parity),
    .sel(par_off[2 +: IW]), .word_o(par_word));

  always_comb begin
    bus_rdata = 32'd0;
    case (bus_addr)
      OFS_ENC_CTL:  bus_rdata[0] = enc_en;
      OFS_ENC_CFG:  bus_rdata = enc_cfg;
      OFS_ENC_SRC:  bus_rdata = enc_src_addr;
      OFS_ENC_IDLE: bus_rdata[0] = !enc_busy;
      OFS_ENC_IE:   bus_rdata[0] = enc_ie;
      OFS_ENC_IS:   bus_rdata[0] = enc_sta;
      OFS_DEC_CTL: begin
        bus_rdata[0] = dec_en;
        bus_rdata[4 +: SW] = dec_last;
      end
      OFS_DEC_CFG:  bus_rdata = dec_cfg;
      OFS_DEC_IDLE: bus_rdata[0] = !dec_busy;
      OFS_DEC_MASK: bus_rdata[SECTORS-1:0] = dec_sector_mask;
      OFS_DEC_IE:   bus_rdata[0] = dec_ie;
      OFS_DEC_IS:   bus_rdata[0] = dec_sta;
      default:      if (par_hit) bus_rdata = par_word;
    endcase
  end

  assign irq = (enc_sta && enc_ie) || (dec_sta && dec_ie);

  // R8: interrupt line follows enabled status across the two halves
  assert_irq_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((enc_sta && enc_ie) || (dec_sta && dec_ie)) |-> irq);
  assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(enc_sta && enc_ie) && !(dec_sta && dec_ie)) |-> !irq);
  // R6: decoder status only rises when the last-sector bit was set
  assert_dec_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_sta) |-> $past(dec_done && dec_sector_mask[dec_last]));
  // R2: capability is always in the legal 4..60 range and even
  assert_tcap_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_tcap >= 6'd4) && (enc_tcap <= 6'd60) && !enc_tcap[0]);
endmodule

// File: tb/tb_ecc_regif.sv
`timescale 1ns/1ps
module tb_ecc_regif;
  localparam int PW = 8;
  localparam int NS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic enc_start, enc_done = 0, dec_start, dec_done = 0, irq;
  logic [PW*32-1:0] enc_parity = '0;
  logic [NS-1:0] dec_sector_mask = '0;
  logic [31:0] enc_cfg, enc_src_addr, dec_cfg;
  logic [5:0] enc_tcap, dec_tcap;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  ecc_regif #(.PAR_WORDS(PW), .SECTORS(NS)) dut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic pulse_enc_done();
    @(negedge clk); enc_done = 1;
    @(posedge clk); #1 enc_done = 0;
  endtask

  task automatic pulse_dec_done(input logic [NS-1:0] m);
    @(negedge clk); dec_done = 1; dec_sector_mask = m;
    @(posedge clk); #1 dec_done = 0;
  endtask

  function automatic int cap_ref(input int c);
    int tbl[20] = '{4,6,8,10,12,14,16,18,20,22,24,28,32,36,40,44,48,52,56,60};
    return (c < 20) ? tbl[c] : 4;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h00C, d); chk("R1 enc idle", d, 1);
    rd(12'h10C, d); chk("R1 dec idle", d, 1);
    rd(12'h000, d); chk("R1 enc en", d, 0);
    rd(12'h084, d); chk("R1 enc sta", d, 0);
    rd(12'h204, d); chk("R1 dec sta", d, 0);
    rd(12'h104, d); chk("R1 dec cfg", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 starts", {enc_start, dec_start}, 0);
  endtask

  task automatic t_strength();
    int codes[7] = '{0, 5, 10, 11, 19, 20, 31};
    foreach (codes[i]) begin
      wr(12'h004, 32'h0040_0000 | codes[i]);
      wr(12'h104, 32'h8000_3000 | codes[(i + 3) % 7]);
      chk("R2 enc tcap", enc_tcap, cap_ref(codes[i]));
      chk("R2 dec tcap", dec_tcap, cap_ref(codes[(i + 3) % 7]));
    end
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(12'h004, 32'h1000_0046);
    wr(12'h104, 32'h8d60_3027);
    wr(12'h008, 32'hCAFE_0040);
    rd(12'h004, d); chk("R3 enc cfg rb", d, 32'h1000_0046);
    rd(12'h104, d); chk("R3 dec cfg rb", d, 32'h8d60_3027);
    rd(12'h008, d); chk("R3 src rb", d, 32'hCAFE_0040);
    chk("R3 enc_cfg port", enc_cfg, 32'h1000_0046);
    chk("R3 dec_cfg port", dec_cfg, 32'h8d60_3027);
    chk("R3 src port", enc_src_addr, 32'hCAFE_0040);
  endtask

  task automatic t_encode();
    logic [31:0] d;
    for (int i = 0; i < PW; i++) enc_parity[i*32 +: 32] = 32'hA500_0000 + i * 32'h1111;
    wr(12'h080, 1);
    wr(12'h000, 1);
    chk("R4 enc start high", enc_start, 1);
    rd(12'h00C, d); chk("R4 enc idle low", d, 0);
    chk("R4 enc start dropped", enc_start, 0);
    wr(12'h000, 1);
    chk("R10 no start while busy", enc_start, 0);
    chk("R8 irq before done", irq, 0);
    pulse_enc_done();
    chk("R8 irq after enc done", irq, 1);
    rd(12'h00C, d); chk("R5 enc idle back", d, 1);
    for (int i = 0; i < PW; i++) begin
      rd(12'h010 + 12'(4 * i), d);
      chk("R5 parity word", d, 32'hA500_0000 + i * 32'h1111);
    end
    rd(12'h084, d); chk("R5 enc sta set", d, 1);
    rd(12'h084, d); chk("R7 enc sta cleared", d, 0);
    chk("R8 irq cleared", irq, 0);
    wr(12'h000, 0);
    rd(12'h000, d); chk("R10 enable cleared", d, 0);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    wr(12'h200, 1);
    wr(12'h100, 32'h0000_0051);  // last sector 5, enable
    chk("R4 dec start", dec_start, 1);
    rd(12'h100, d); chk("R6 dec ctl rb", d, 32'h51);
    pulse_dec_done(16'h001F);    // bit 5 clear
    rd(12'h10C, d); chk("R6 dec idle after miss", d, 1);
    rd(12'h204, d); chk("R6 dec sta not set", d, 0);
    chk("R6 irq low on miss", irq, 0);
    wr(12'h100, 32'h0000_0051);
    pulse_dec_done(16'h0020);
    chk("R8 irq from dec", irq, 1);
    rd(12'h124, d); chk("R9 mask readback", d, 32'h20);
    // set wins over read-clear in same cycle
    rd(12'h204, d); chk("R6 dec sta set", d, 1);
    wr(12'h100, 32'h0000_0051);
    @(negedge clk); bus_rd = 1; bus_addr = 12'h204; dec_done = 1;
    @(posedge clk); #1 bus_rd = 0; dec_done = 0;
    rd(12'h204, d); chk("R7 set wins over read", d, 1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(12'h030, d); chk("R9 beyond parity", d, 0);
    rd(12'h0FC, d); chk("R9 hole", d, 0);
    rd(12'h012, d); chk("R9 misaligned", d, 0);
    rd(12'h300, d); chk("R9 high", d, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_strength();
        t_cfg();
        t_encode();
        t_decode();
        t_unmapped();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule